// File: doc/BRIEF.md
# Control Pin Function Router

This block decides which of a device's shared control pads drive the output-enable, power-down and write-protect functions of a clock generator. Three byte-wide configuration registers hold the routing: a routing register at address 10h, a write-protect control register at 11h, and a bank register at 40h whose two top bits are stored enable bits for the two output divider banks. The registers are loaded through a single-cycle write port and can be read back at any time.

Each function can come either from a selectable pad or from a stored bit. Each has its own polarity and its own enable. Output enable is active high, power-down is active low, and write protect is active high. Pad levels pass through a two-flop synchronizer before use. The routed results are registered on the core clock. They produce two divider-bank enables, a power-down request for the clock core, and a write-protect level. The write-protect level gates the start of erase or program cycles in the nonvolatile memory controller. The serial-shift enable passes through untouched.

Top module: `pinmux_ctl`

## Requirements
- R1: After reset, register 10h reads 52h, 11h reads 04h and 40h reads C0h. A write to 10h, 11h or 40h is read back on the next cycle. A read of any other address returns 00h, and a write to any other address changes no register.
- R2: With 10h bit 7 at 0, bank 0 enable follows the pad chosen by 10h bits 6:5 and bank 1 enable follows the pad chosen by 10h bits 4:3. Select code 2'b10 picks the pin-10 pad (pad_i bit 0). The enables are active high.
- R3: With 10h bit 7 at 1, bank 0 enable equals 40h bit 6 and bank 1 enable equals 40h bit 7, whatever the pad levels.
- R4: With 10h bit 2 at 1, pdown_o is 1 while the pad chosen by 10h bits 1:0 is low. Code 2'b10 picks the pin-10 pad. With 10h bit 2 at 0, pdown_o stays 0.
- R5: While pdown_o is 1, both bank enables are 0.
- R6: With 11h bit 3 at 1, wp_o follows the pad chosen by 11h bits 2:0, active high. Code 3'b100 picks the pin-17 pad (pad_i bit 1). With 11h bit 3 at 0, wp_o equals 11h bit 4.
- R7: While wp_o is 1, prog_go_o is 0. Otherwise prog_go_o equals prog_req_i. shift_en_o always equals shift_en_i, whatever the write-protect level.
- R8: A pad select code that maps to no pad forces its function inactive: bank disabled, no power-down, no write protect.
- R9: A pad change reaches the outputs on the third rising edge after it is applied, and not before. A register write reaches the outputs on the rising edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Read data (combinational) |
| pad_i | input | 2 | Raw pad levels: bit 0 pin-10 pad, bit 1 pin-17 pad |
| prog_req_i | input | 1 | Memory controller request to start erase/program |
| prog_go_o | output | 1 | Permitted erase/program start |
| shift_en_i | input | 1 | Serial shift enable from the serial port |
| shift_en_o | output | 1 | Serial shift enable toward the memory |
| bank_en_o | output | 2 | Divider-bank enables, bit 0 is bank 0 |
| pdown_o | output | 1 | Clock-core power-down request |
| wp_o | output | 1 | Routed write-protect level |

## Verification
The assertions check four things on every cycle: that an asserted power-down never leaves a bank enabled, that write protect always blocks an erase/program start, that the shift enable passes through, and that a disabled power-down function never raises pdown_o. Register write-then-read consistency is checked the same way. Only the bench scenarios can show that each select code reaches the right pad with the right polarity, that unmapped codes fall inactive, that the memory-sourced bank bits land on the right banks, and the exact synchronizer latency.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int DW = 8;
  localparam int AW = 8;

  localparam logic [AW-1:0] ADDR_ROUTE = 8'h10;
  localparam logic [AW-1:0] ADDR_WPCTL = 8'h11;
  localparam logic [AW-1:0] ADDR_BANK  = 8'h40;

  localparam logic [DW-1:0] RST_ROUTE = 8'h52;
  localparam logic [DW-1:0] RST_WPCTL = 8'h04;
  localparam logic [DW-1:0] RST_BANK  = 8'hC0;

  // pad positions on pad_i
  localparam int PAD_PIN10 = 0;
  localparam int PAD_PIN17 = 1;
  localparam int NUM_PADS  = 2;

  // select codes that map to a pad
  localparam logic [1:0] SEL2_PIN10 = 2'b10;
  localparam logic [2:0] SEL3_PIN17 = 3'b100;

  typedef struct packed {
    logic       oe_from_mem;
    logic [1:0] bank0_sel;
    logic [1:0] bank1_sel;
    logic       pd_enable;
    logic [1:0] pd_sel;
  } route_cfg_t;

  typedef struct packed {
    logic [2:0] spare;
    logic       wp_stored;
    logic       wp_from_pad;
    logic [2:0] wp_sel;
  } wp_cfg_t;
endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs
  import pinmux_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output route_cfg_t    route_q,
  output wp_cfg_t       wpctl_q,
  output logic [DW-1:0] bank_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      route_q <= route_cfg_t'(RST_ROUTE);
      wpctl_q <= wp_cfg_t'(RST_WPCTL);
      bank_q  <= RST_BANK;
    end else if (wr_en) begin
      unique case (wr_addr)
        ADDR_ROUTE: route_q <= route_cfg_t'(wr_data);
        ADDR_WPCTL: wpctl_q <= wp_cfg_t'(wr_data);
        ADDR_BANK:  bank_q  <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (rd_addr)
      ADDR_ROUTE: rd_data = DW'(route_q);
      ADDR_WPCTL: rd_data = DW'(wpctl_q);
      ADDR_BANK:  rd_data = bank_q;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  localparam int LAST = STAGES - 1;

  for (genvar g = 0; g < WIDTH; g++) begin : g_pad
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], async_i[g]};
    end
    assign sync_o[g] = chain_q[LAST];
  end
endmodule

// File: rtl/pinmux_route.sv
module pinmux_route
  import pinmux_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  route_cfg_t          route_q,
  input  wp_cfg_t             wpctl_q,
  input  logic [DW-1:0]       bank_q,
  input  logic [NUM_PADS-1:0] pad_s,
  output logic [1:0]          bank_en_q,
  output logic                pdown_q,
  output logic                wp_q
);
  localparam int NBANK = 2;

  // level of the pad picked by a 2-bit code, or the given idle level
  function automatic logic pick2(input logic [1:0] code,
                                 input logic [NUM_PADS-1:0] p,
                                 input logic idle);
    return (code == SEL2_PIN10) ? p[PAD_PIN10] : idle;
  endfunction

  function automatic logic pick3(input logic [2:0] code,
                                 input logic [NUM_PADS-1:0] p,
                                 input logic idle);
    return (code == SEL3_PIN17) ? p[PAD_PIN17] : idle;
  endfunction

  logic [1:0] bank_sel [NBANK];
  logic [NBANK-1:0] bank_pad, bank_mem, bank_d;
  logic pd_level, pdown_d, wp_d;

  assign bank_sel[0] = route_q.bank0_sel;
  assign bank_sel[1] = route_q.bank1_sel;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    // idle level of an enable is 0 (bank off)
    assign bank_pad[b] = pick2(bank_sel[b], pad_s, 1'b0);
    assign bank_mem[b] = bank_q[DW-NBANK+b];
  end

  always_comb begin
    // power-down pad is active low; idle level is high (not asserted)
    pd_level = pick2(route_q.pd_sel, pad_s, 1'b1);
    pdown_d  = route_q.pd_enable & ~pd_level;
    bank_d   = route_q.oe_from_mem ? bank_mem : bank_pad;
    if (pdown_d) bank_d = '0;
    wp_d = wpctl_q.wp_from_pad ? pick3(wpctl_q.wp_sel, pad_s, 1'b0)
                               : wpctl_q.wp_stored;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_en_q <= '0;
      pdown_q   <= 1'b0;
      wp_q      <= 1'b0;
    end else begin
      bank_en_q <= bank_d;
      pdown_q   <= pdown_d;
      wp_q      <= wp_d;
    end
  end
endmodule

// File: rtl/pinmux_ctl.sv
module pinmux_ctl
  import pinmux_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [DW-1:0]       rd_data,
  input  logic [NUM_PADS-1:0] pad_i,
  input  logic                prog_req_i,
  output logic                prog_go_o,
  input  logic                shift_en_i,
  output logic                shift_en_o,
  output logic [1:0]          bank_en_o,
  output logic                pdown_o,
  output logic                wp_o
);
  route_cfg_t          route_q;
  wp_cfg_t             wpctl_q;
  logic [DW-1:0]       bank_q;
  logic [NUM_PADS-1:0] pad_s;

  pinmux_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .route_q (route_q),
    .wpctl_q (wpctl_q),
    .bank_q  (bank_q)
  );

  pinmux_sync #(.WIDTH(NUM_PADS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (pad_i),
    .sync_o  (pad_s)
  );

  pinmux_route u_route (
    .clk       (clk),
    .rst       (rst),
    .route_q   (route_q),
    .wpctl_q   (wpctl_q),
    .bank_q    (bank_q),
    .pad_s     (pad_s),
    .bank_en_q (bank_en_o),
    .pdown_q   (pdown_o),
    .wp_q      (wp_o)
  );

  assign prog_go_o  = prog_req_i & ~wp_o;
  assign shift_en_o = shift_en_i;
endmodule

// File: rtl/pinmux_ctl_chk.sv
module pinmux_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       pd_enable,
  input logic       wr_en,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [7:0] rd_addr,
  input logic [7:0] rd_data,
  input logic       prog_req_i,
  input logic       prog_go_o,
  input logic       shift_en_i,
  input logic       shift_en_o,
  input logic [1:0] bank_en_o,
  input logic       pdown_o,
  input logic       wp_o
);
  // R5
  pdown_gates_banks_chk: assert property (@(posedge clk) disable iff (rst)
    pdown_o |-> (bank_en_o == 2'b00));

  // R7
  wp_blocks_prog_chk: assert property (@(posedge clk) disable iff (rst)
    wp_o |-> !prog_go_o);

  // R7
  prog_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!wp_o && prog_req_i) |-> prog_go_o);

  // R7
  shift_pass_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en_o == shift_en_i);

  // R4
  pd_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    !pd_enable |=> !pdown_o);

  // R1
  route_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 8'h10) |=> (rd_addr != 8'h10 || rd_data == $past(wr_data)));
endmodule

bind pinmux_ctl pinmux_ctl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .pd_enable  (route_q.pd_enable),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .prog_req_i (prog_req_i),
  .prog_go_o  (prog_go_o),
  .shift_en_i (shift_en_i),
  .shift_en_o (shift_en_o),
  .bank_en_o  (bank_en_o),
  .pdown_o    (pdown_o),
  .wp_o       (wp_o)
);

// File: tb/pinmux_ctl_tb.sv
module pinmux_ctl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [7:0] rd_data;
  logic [1:0] pad_i = '0;
  logic prog_req_i = 1'b0, shift_en_i = 1'b0;
  logic prog_go_o, shift_en_o, pdown_o, wp_o;
  logic [1:0] bank_en_o;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  pinmux_ctl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pad_i(pad_i),
    .prog_req_i(prog_req_i), .prog_go_o(prog_go_o),
    .shift_en_i(shift_en_i), .shift_en_o(shift_en_o),
    .bank_en_o(bank_en_o), .pdown_o(pdown_o), .wp_o(wp_o)
  );

  // {route, wpctl, bank, pads, exp_bank, exp_pdown, exp_wp}
  localparam int NV = 14;
  localparam logic [29:0] VEC [NV] = '{
    {8'h52, 8'h04, 8'hC0, 2'b01, 2'b11, 1'b0, 1'b0},
    {8'h52, 8'h04, 8'hC0, 2'b00, 2'b00, 1'b0, 1'b0},
    {8'h86, 8'h04, 8'hC0, 2'b00, 2'b00, 1'b1, 1'b0},
    {8'h86, 8'h04, 8'hC0, 2'b01, 2'b11, 1'b0, 1'b0},
    {8'h86, 8'h04, 8'h40, 2'b01, 2'b01, 1'b0, 1'b0},
    {8'h80, 8'h04, 8'h80, 2'b00, 2'b10, 1'b0, 1'b0},
    {8'h40, 8'h04, 8'hC0, 2'b01, 2'b01, 1'b0, 1'b0},
    {8'h52, 8'h1C, 8'hC0, 2'b01, 2'b11, 1'b0, 1'b0},
    {8'h52, 8'h1C, 8'hC0, 2'b11, 2'b11, 1'b0, 1'b1},
    {8'h52, 8'h10, 8'hC0, 2'b01, 2'b11, 1'b0, 1'b1},
    {8'h52, 8'h0D, 8'hC0, 2'b11, 2'b11, 1'b0, 1'b0},
    {8'h85, 8'h04, 8'hC0, 2'b00, 2'b11, 1'b0, 1'b0},
    {8'h56, 8'h04, 8'hC0, 2'b00, 2'b00, 1'b1, 1'b0},
    {8'h30, 8'h04, 8'hC0, 2'b01, 2'b10, 1'b0, 1'b0}
  };

  function automatic string vec_req(input int i);
    case (i)
      0, 1, 13:  return "R2";
      2, 12:     return "R4/R5";
      3:         return "R4";
      4, 5:      return "R3";
      6:         return "R8(bank1 unmapped) R2";
      7, 8, 9:   return "R6";
      10, 11:    return "R8";
      default:   return "R2";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(req, $sformatf("read %0h", a), rd_data, exp);
  endtask

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset values and readback
    rd_chk("R1", 8'h10, 8'h52);
    rd_chk("R1", 8'h11, 8'h04);
    rd_chk("R1", 8'h40, 8'hC0);
    rd_chk("R1", 8'h22, 8'h00);
    chk("R1", "reset wp", {7'd0, wp_o}, 8'h00);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [29:0] v;
      v = VEC[i];
      wr(8'h10, v[29:22]);
      wr(8'h11, v[21:14]);
      wr(8'h40, v[13:6]);
      pad_i = v[5:4];
      prog_req_i = 1'b1;
      repeat (5) @(negedge clk);
      chk(vec_req(i), $sformatf("vec%0d bank", i), {6'd0, bank_en_o}, {6'd0, v[3:2]});
      chk(vec_req(i), $sformatf("vec%0d pdown", i), {7'd0, pdown_o}, {7'd0, v[1]});
      chk(vec_req(i), $sformatf("vec%0d wp", i), {7'd0, wp_o}, {7'd0, v[0]});
      // R7 program start gated by write protect
      chk("R7", $sformatf("vec%0d prog_go", i), {7'd0, prog_go_o}, {7'd0, ~v[0]});
      rd_chk("R1", 8'h10, v[29:22]);
    end

    // R7: shifting unaffected under write protect
    wr(8'h11, 8'h10);
    repeat (3) @(negedge clk);
    shift_en_i = 1'b1; #1;
    chk("R7", "shift under wp", {7'd0, shift_en_o}, 8'h01);
    shift_en_i = 1'b0; #1;
    chk("R7", "shift low under wp", {7'd0, shift_en_o}, 8'h00);
    prog_req_i = 1'b0;

    // R1: write to unmapped address ignored
    wr(8'h11, 8'h04);
    wr(8'h52, 8'hFF);
    rd_chk("R1", 8'h52, 8'h00);
    rd_chk("R1", 8'h10, 8'h30);
    rd_chk("R1", 8'h11, 8'h04);
    rd_chk("R1", 8'h40, 8'hC0);

    // R9: pad latency, route 10h=52h with pin10 pad
    wr(8'h10, 8'h52);
    pad_i = 2'b00;
    repeat (5) @(negedge clk);
    pad_i = 2'b01;
    repeat (2) @(negedge clk);
    chk("R9", "pad after 2 edges", {6'd0, bank_en_o}, 8'h00);
    @(negedge clk);
    chk("R9", "pad after 3 edges", {6'd0, bank_en_o}, 8'h03);

    // R9: register write latency, switch to stored bits 40h=40h
    wr(8'h40, 8'h40);
    @(negedge clk);
    chk("R9", "write then 1 more edge", {6'd0, bank_en_o}, 8'h03);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'h10; wr_data = 8'h80;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9", "at write edge", {6'd0, bank_en_o}, 8'h03);
    @(negedge clk);
    chk("R9", "edge after write", {6'd0, bank_en_o}, 8'h01);

    // R1: reset mid-run restores defaults
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd_chk("R1", 8'h10, 8'h52);
    rd_chk("R1", 8'h40, 8'hC0);
    summary();
  end
endmodule